// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Hit Qualifier

This block decides which raw comparator hits of a processor's hardware debug unit become real debug events. A bank of breakpoint comparators and a bank of watchpoint comparators each raise a raw address-match hit. Each comparator also has a 64-bit control word. The qualifier filters every hit by three things: the current security state, the current privilege level, and an optional link to a context-aware breakpoint that compares the running context ID. A global monitor-debug enable and a debug-mask input can suppress everything at once.

One request carries the full picture of the bank: the raw hit vectors, all control and value words, the level, the security state, the unprivileged-access flag and the context ID. The request is accepted over a valid/ready handshake. One clock after acceptance the block presents, for each bank, whether any comparator qualified and the lowest qualified index. The result stays on the outputs while the consumer holds `out_ready` low. During that time `in_ready` stays low, so a new request is accepted only when the previous result is taken in the same cycle or has already gone. Address comparison, access-type matching and raising the exception are left to the neighbouring logic.

Top module: `dbg_hit_qualifier`

## Requirements
- R1: A comparator can qualify only if its raw hit bit is set. Inputs are captured on the cycle where `in_valid` and `in_ready` are both high, and the result appears on the outputs with `out_valid` high on the following cycle.
- R2: The security field is control bits 15:14. Value 0 passes in either state, value 2 passes only when `secure` is 1, and values 1 and 3 pass only when `secure` is 0.
- R3: Privilege check on the effective level: at level 2 or 3 control bit 13 must be 1, at level 1 control bit 1 must be 1, and at level 0 control bit 2 must be 1.
- R4: When `unpriv` is 1, watchpoints use level 0 as the effective level for R3, whatever `cur_el` is. Breakpoints always use `cur_el`.
- R5: When control bit 20 (the link flag) is 1, the linked breakpoint number in control bits 19:16 must satisfy `brp_max - ctx_cnt <= n <= brp_max` (a negative lower bound counts as 0). It must also name an existing breakpoint. Otherwise the hit is dropped.
- R6: A linked breakpoint n passes only if all of these hold: its control bit 0 is 1, its type field (control bits 23:20) equals 3, `cur_el` is 0 or 1, and `ctx_id` equals bits 31:0 of its value word. Every other type code gives no event.
- R7: When bit 15 of `dbg_ctrl` is 0, or `dbg_masked` is 1, no comparator qualifies.
- R8: For each bank, `*_any` is 1 if any comparator qualified. `*_idx` is the lowest qualified index, or 0 when none qualified.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values.
- R10: After reset `out_valid`, `bp_any` and `wp_any` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| bp_hit | input | NBP | Raw breakpoint address hits |
| wp_hit | input | NWP | Raw watchpoint hits |
| bp_ctrl | input | NBP x 64 | Breakpoint control words |
| bp_value | input | NBP x 64 | Breakpoint value words (context compare) |
| wp_ctrl | input | NWP x 64 | Watchpoint control words |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | Current security state (1 = secure) |
| unpriv | input | 1 | Watchpoint access came from an unprivileged load/store |
| dbg_ctrl | input | 32 | Debug control word; bit 15 is the monitor-debug enable |
| dbg_masked | input | 1 | Debug exceptions currently masked |
| ctx_id | input | 32 | Current context ID |
| brp_max | input | 4 | Highest breakpoint index |
| ctx_cnt | input | 4 | Number of context-aware breakpoints minus one |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| bp_any | output | 1 | Some breakpoint qualified |
| bp_idx | output | log2(NBP) | Lowest qualified breakpoint |
| wp_any | output | 1 | Some watchpoint qualified |
| wp_idx | output | log2(NWP) | Lowest qualified watchpoint |

## Verification
The assertions assume the inputs are at known values whenever reset is released. They also assume that `cur_el`, `secure` and the register words change only when the bench means to present a new request, so a held result can be compared with itself. The stimulus drives every input to a defined value before reset is released and changes inputs only at the falling clock edge. The sweeps walk the security, privilege, higher-level and unprivileged combinations, every linked number and type code under three link-range settings, and every hit pattern of a four-comparator bank. Each walk stays inside the declared field encodings.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;
  localparam int CTRL_W   = 64;
  localparam int CTX_W    = 32;
  localparam int NUM_W    = 4;
  localparam int NUM_LIM  = 1 << NUM_W;
  localparam int EN_BIT   = 0;
  localparam int PRIV_LO  = 1;
  localparam int HMC_BIT  = 13;
  localparam int SEC_LO   = 14;
  localparam int SEC_HI   = 15;
  localparam int LBN_LO   = 16;
  localparam int LBN_HI   = 19;
  localparam int LINK_BIT = 20;
  localparam int TYPE_LO  = 20;
  localparam int TYPE_HI  = 23;
  localparam int GDE_BIT  = 15;
  localparam logic [3:0] CTX_MATCH_TYPE = 4'd3;
endpackage

// File: rtl/dbgq_first.sv
module dbgq_first #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dbgq_link_eval.sv
module dbgq_link_eval
  import dbgq_pkg::*;
#(
  parameter int NBP = 16
) (
  input  logic [NBP-1:0][CTRL_W-1:0] bp_ctrl,
  input  logic [NBP-1:0][CTRL_W-1:0] bp_value,
  input  logic [NUM_W-1:0]           brp_max,
  input  logic [NUM_W-1:0]           ctx_cnt,
  input  logic [1:0]                 cur_el,
  input  logic [CTX_W-1:0]           ctx_id,
  output logic [NBP-1:0]             link_ok
);
  logic el_low;
  assign el_low = (cur_el <= 2'd1);

  for (genvar k = 0; k < NBP; k++) begin : g_slot
    logic unused_bits;
    assign unused_bits = ^{bp_ctrl[k][CTRL_W-1:TYPE_HI+1],
                           bp_ctrl[k][TYPE_LO-1:EN_BIT+1],
                           bp_value[k][CTRL_W-1:CTX_W]};
    if (k < NUM_LIM) begin : g_reach
      localparam logic [NUM_W:0] KV = (NUM_W + 1)'(k);
      logic in_rng;
      // k >= brp_max - ctx_cnt rewritten without a negative bound
      assign in_rng = (KV <= {1'b0, brp_max}) &&
                      ((KV + {1'b0, ctx_cnt}) >= {1'b0, brp_max});
      assign link_ok[k] = in_rng && bp_ctrl[k][EN_BIT] &&
                          (bp_ctrl[k][TYPE_HI:TYPE_LO] == CTX_MATCH_TYPE) &&
                          el_low && (bp_value[k][CTX_W-1:0] == ctx_id);
    end else begin : g_far
      assign link_ok[k] = 1'b0;
    end
  end
endmodule

// File: rtl/dbgq_filter.sv
module dbgq_filter
  import dbgq_pkg::*;
#(
  parameter int NBP = 16
) (
  input  logic              raw,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [1:0]        el,
  input  logic              secure,
  input  logic [NBP-1:0]    link_ok,
  output logic              qual
);
  logic [NUM_LIM-1:0] link_pad;
  logic sec_ok, priv_ok, link_pass;
  logic unused_bits;

  for (genvar j = 0; j < NUM_LIM; j++) begin : g_pad
    if (j < NBP) begin : g_in
      assign link_pad[j] = link_ok[j];
    end else begin : g_out
      assign link_pad[j] = 1'b0;
    end
  end

  always_comb begin
    unique case (ctrl[SEC_HI:SEC_LO])
      2'd0:    sec_ok = 1'b1;
      2'd2:    sec_ok = secure;
      default: sec_ok = !secure;
    endcase
  end

  always_comb begin
    unique case (el)
      2'd0:    priv_ok = ctrl[PRIV_LO+1];
      2'd1:    priv_ok = ctrl[PRIV_LO];
      default: priv_ok = ctrl[HMC_BIT];
    endcase
  end

  assign link_pass = !ctrl[LINK_BIT] || link_pad[ctrl[LBN_HI:LBN_LO]];
  assign qual      = raw && sec_ok && priv_ok && link_pass;
  assign unused_bits = ^{ctrl[CTRL_W-1:LINK_BIT+1],
                         ctrl[HMC_BIT-1:PRIV_LO+2], ctrl[EN_BIT]};
endmodule

// File: rtl/dbg_hit_qualifier.sv
module dbg_hit_qualifier
  import dbgq_pkg::*;
#(
  parameter int NBP = 16,
  parameter int NWP = 16,
  localparam int BIW = $clog2(NBP),
  localparam int WIW = $clog2(NWP)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NBP-1:0]             bp_hit,
  input  logic [NWP-1:0]             wp_hit,
  input  logic [NBP-1:0][CTRL_W-1:0] bp_ctrl,
  input  logic [NBP-1:0][CTRL_W-1:0] bp_value,
  input  logic [NWP-1:0][CTRL_W-1:0] wp_ctrl,
  input  logic [1:0]                 cur_el,
  input  logic                       secure,
  input  logic                       unpriv,
  input  logic [31:0]                dbg_ctrl,
  input  logic                       dbg_masked,
  input  logic [CTX_W-1:0]           ctx_id,
  input  logic [NUM_W-1:0]           brp_max,
  input  logic [NUM_W-1:0]           ctx_cnt,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic                       bp_any,
  output logic [BIW-1:0]             bp_idx,
  output logic                       wp_any,
  output logic [WIW-1:0]             wp_idx
);
  logic [NBP-1:0] link_ok, q_bp, g_bp;
  logic [NWP-1:0] q_wp, g_wp;
  logic [1:0]     wp_el;
  logic           gate_open, accept;
  logic           n_bp_any, n_wp_any;
  logic [BIW-1:0] n_bp_idx;
  logic [WIW-1:0] n_wp_idx;
  logic           unused_dctl;

  assign unused_dctl = ^{dbg_ctrl[31:GDE_BIT+1], dbg_ctrl[GDE_BIT-1:0]};

  dbgq_link_eval #(.NBP(NBP)) u_link (
    .bp_ctrl (bp_ctrl),
    .bp_value(bp_value),
    .brp_max (brp_max),
    .ctx_cnt (ctx_cnt),
    .cur_el  (cur_el),
    .ctx_id  (ctx_id),
    .link_ok (link_ok)
  );

  // unprivileged load/store: watchpoints judged as level 0
  assign wp_el = unpriv ? 2'd0 : cur_el;

  for (genvar b = 0; b < NBP; b++) begin : g_bp_f
    dbgq_filter #(.NBP(NBP)) u_f (
      .raw(bp_hit[b]), .ctrl(bp_ctrl[b]), .el(cur_el), .secure(secure),
      .link_ok(link_ok), .qual(q_bp[b])
    );
  end

  for (genvar w = 0; w < NWP; w++) begin : g_wp_f
    dbgq_filter #(.NBP(NBP)) u_f (
      .raw(wp_hit[w]), .ctrl(wp_ctrl[w]), .el(wp_el), .secure(secure),
      .link_ok(link_ok), .qual(q_wp[w])
    );
  end

  assign gate_open = dbg_ctrl[GDE_BIT] && !dbg_masked;
  assign g_bp      = q_bp & {NBP{gate_open}};
  assign g_wp      = q_wp & {NWP{gate_open}};

  dbgq_first #(.N(NBP), .IW(BIW)) u_bp_first (.vec(g_bp), .any(n_bp_any), .idx(n_bp_idx));
  dbgq_first #(.N(NWP), .IW(WIW)) u_wp_first (.vec(g_wp), .any(n_wp_any), .idx(n_wp_idx));

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      bp_any    <= 1'b0;
      bp_idx    <= '0;
      wp_any    <= 1'b0;
      wp_idx    <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      bp_any    <= n_bp_any;
      bp_idx    <= n_bp_idx;
      wp_any    <= n_wp_any;
      wp_idx    <= n_wp_idx;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: a qualified comparator always had its raw hit
  p_raw_needed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_bp & ~bp_hit) == '0) && ((q_wp & ~wp_hit) == '0));

  // R6: context links never pass above level 1
  p_ctx_el_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_el > 2'd1) |-> (link_ok == '0));

  // R7: closed gate lets nothing into the encoders
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |-> (!n_bp_any && !n_wp_any));

  // R9: stalled result holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({bp_any, bp_idx, wp_any, wp_idx})));

  // R1: a new result needs an accepted request
  p_valid_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));
endmodule

// File: tb/sim_dbg_hit_qualifier.sv
`timescale 1ns/1ps
module sim_dbg_hit_qualifier;
  localparam int NB = 4;
  localparam int NW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iv = 1'b0, ordy = 1'b1;
  logic [NB-1:0] b_hit = '0;
  logic [NW-1:0] w_hit = '0;
  logic [NB-1:0][63:0] b_ctl = '0, b_val = '0;
  logic [NW-1:0][63:0] w_ctl = '0;
  logic [1:0]  el = 2'd0;
  logic        sec = 1'b0, up = 1'b0, dmask = 1'b0;
  logic [31:0] dctl = 32'h0000_8000;
  logic [31:0] ctx = 32'h1234_5678;
  logic [3:0]  brpm = 4'd3, ccnt = 4'd1;
  logic        in_ready, out_valid, bp_any, wp_any;
  logic [1:0]  bp_idx, wp_idx;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dbg_hit_qualifier #(.NBP(NB), .NWP(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_ready(in_ready),
    .bp_hit(b_hit), .wp_hit(w_hit), .bp_ctrl(b_ctl), .bp_value(b_val),
    .wp_ctrl(w_ctl), .cur_el(el), .secure(sec), .unpriv(up),
    .dbg_ctrl(dctl), .dbg_masked(dmask), .ctx_id(ctx), .brp_max(brpm),
    .ctx_cnt(ccnt), .out_valid(out_valid), .out_ready(ordy),
    .bp_any(bp_any), .bp_idx(bp_idx), .wp_any(wp_any), .wp_idx(wp_idx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected qualification from the requirements
  function automatic bit mq(bit is_wp, logic [63:0] c);
    int e;
    int n;
    bit s, p, l;
    e = (is_wp && up) ? 0 : int'(el);
    case (c[15:14])
      2'd0: s = 1;
      2'd2: s = sec;
      default: s = !sec;
    endcase
    if (e >= 2) p = c[13];
    else if (e == 1) p = c[1];
    else p = c[2];
    l = 1;
    if (c[20]) begin
      n = int'(c[19:16]);
      if (n > int'(brpm) || n < int'(brpm) - int'(ccnt) || n >= NB) l = 0;
      else l = b_ctl[n][0] && (b_ctl[n][23:20] == 4'd3) && (el <= 2'd1) &&
               (b_val[n][31:0] == ctx);
    end
    return s && p && l && dctl[15] && !dmask;
  endfunction

  task automatic compare(input string tag);
    bit ea, wa;
    int ei, wi;
    ea = 0; wa = 0; ei = 0; wi = 0;
    for (int i = NB - 1; i >= 0; i--)
      if (b_hit[i] && mq(0, b_ctl[i])) begin ea = 1; ei = i; end
    for (int i = NW - 1; i >= 0; i--)
      if (w_hit[i] && mq(1, w_ctl[i])) begin wa = 1; wi = i; end
    chk({tag, " bp"}, {29'd0, out_valid, bp_any, 1'b0} | 32'(bp_idx) << 8,
        {29'd0, 1'b1, ea, 1'b0} | 32'(ei) << 8);
    chk({tag, " wp"}, {30'd0, wp_any, 1'b0} | 32'(wp_idx) << 8,
        {30'd0, wa, 1'b0} | 32'(wi) << 8);
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    iv = 1'b1;
    @(posedge clk);
    @(negedge clk);
    iv = 1'b0;
    compare(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid", {31'd0, out_valid}, 0);
    chk("R10 any", {30'd0, bp_any, wp_any}, 0);
    chk("R10 in_ready", {31'd0, in_ready}, 1);
    rst_n = 1'b1;

    // R2 R3 R4: sweep on comparator 0 of both banks
    b_hit = 4'b0001; w_hit = 4'b0001;
    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 2; s++)
        for (int sc = 0; sc < 4; sc++)
          for (int pc = 0; pc < 4; pc++)
            for (int h = 0; h < 2; h++)
              for (int u = 0; u < 2; u++) begin
                el = 2'(e); sec = 1'(s); up = 1'(u);
                b_ctl[0] = '0;
                b_ctl[0][15:14] = 2'(sc); b_ctl[0][2:1] = 2'(pc); b_ctl[0][13] = 1'(h);
                w_ctl[0] = b_ctl[0];
                step("R2/R3/R4 sweep (R2 R3 R4)");
              end
    up = 0; sec = 0;

    // R5 R6: link range and type sweep on watchpoint 0
    w_hit = 4'b0001; b_hit = '0;
    for (int cfg = 0; cfg < 3; cfg++) begin
      brpm = (cfg == 2) ? 4'd2 : 4'd3;
      ccnt = (cfg == 0) ? 4'd1 : (cfg == 1) ? 4'd3 : 4'd0;
      for (int n = 0; n < 16; n++)
        for (int t = 0; t < 16; t++)
          for (int en = 0; en < 2; en++)
            for (int e = 0; e < 4; e++)
              for (int m = 0; m < 2; m++) begin
                el = 2'(e);
                for (int k = 0; k < NB; k++) begin
                  b_ctl[k] = '0;
                  b_ctl[k][0] = 1'(en);
                  b_ctl[k][23:20] = 4'(t);
                  b_val[k] = {32'hdead_beef, (m != 0) ? ctx : ~ctx};
                end
                w_ctl[0] = '0;
                w_ctl[0][20] = 1'b1; w_ctl[0][19:16] = 4'(n);
                w_ctl[0][2:1] = 2'b11; w_ctl[0][13] = 1'b1;
                step("R5/R6 link (R5 R6)");
              end
    end
    brpm = 4'd3; ccnt = 4'd1; el = 2'd1;

    // R8 R1: every hit pattern, all comparators passing
    for (int k = 0; k < NB; k++) begin
      b_ctl[k] = '0; b_ctl[k][2:1] = 2'b11; b_ctl[k][13] = 1'b1;
      w_ctl[k] = b_ctl[k];
    end
    for (int p = 0; p < 16; p++) begin
      b_hit = 4'(p); w_hit = ~4'(p);
      step("R8 priority / R1 raw");
    end

    // R7: gate closed by enable bit and by mask
    b_hit = 4'b1111; w_hit = 4'b1111;
    dctl = 32'hffff_7fff; step("R7 enable clear");
    dctl = 32'h0000_8000; dmask = 1'b1; step("R7 masked");
    dmask = 1'b0; step("R7 open");

    // R9 R1: back-pressure hold
    @(negedge clk);
    b_hit = 4'b0100; w_hit = 4'b0010; iv = 1'b1; ordy = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 result one cycle later", {30'd0, out_valid, bp_any} | 32'(bp_idx) << 4, 32'h23);
    chk("R9 in_ready low", {31'd0, in_ready}, 0);
    b_hit = 4'b0001; w_hit = 4'b0001;
    @(posedge clk); @(negedge clk);
    chk("R9 held bp", {30'd0, out_valid, bp_any} | 32'(bp_idx) << 4, 32'h23);
    chk("R9 held wp", {31'd0, wp_any} | 32'(wp_idx) << 4, 32'h11);
    ordy = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 new accepted", {30'd0, out_valid, bp_any} | 32'(bp_idx) << 4, 32'h03);
    iv = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 drained", {31'd0, out_valid}, 0);
    chk("R9 ready", {31'd0, in_ready}, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule